// File: doc/BRIEF.md
# Stochastic Bitstream Integrator

This block accumulates a signed 16-bit sample stream without an adder-and-register accumulator. Every accepted sample is turned into a single random bit. The probability that the bit is '1' is set by where the sample lies within a programmable full-scale range [-C, C]. A '1' drives the up port of a saturating up/down counter and a '0' drives its down port. Over many samples, the counter's net count follows the integral of the input, scaled so that a sample x gives an expected net change of x/C per sample.

The random bits come from a maximal-length Galois LFSR. The LFSR value is scaled onto [-C, C) and compared with the sample. The LFSR advances once for each accepted sample, so the bit sequence depends only on the sequence of accepted samples since reset. Two enables gate the up and down ports. Each direction can be suppressed on its own. A controller uses this to stop or bend integration while its output is limited.

Samples enter over a valid/ready handshake. `in_ready` is low during reset and in the cycle of reset, and high from the first cycle after reset. No back-pressure is applied after that. A sample is taken on each rising edge where `in_valid` and `in_ready` are both high. One cycle later, `out_valid` pulses with the updated counter and the pulse that was applied. The result side has no ready input, so the result must be captured in that cycle.

Top module: `stoch_integrator`

## Requirements
- R1: While `rst` is high, and on the first edge after it: `integ_o` is 0, `out_valid` is 0, `in_ready` is 0, and both pulse outputs are 0.
- R2: If `range_c` is greater than 0 and the sample is at least +`range_c`, the random bit is '1' on every accepted sample. When `up_en` is 1, `pulse_up_o` is then 1 in the next cycle.
- R3: If `range_c` is greater than 0 and the sample is at most -`range_c`, the random bit is '0' on every accepted sample. When `dn_en` is 1, `pulse_dn_o` is then 1 in the next cycle.
- R4: For a sample x inside (-C, C), the long-run fraction of '1' bits is (x/C + 1)/2. For C = 32768 this means about 1/2 for x = 0, 3/4 for x = 16384 and 1/4 for x = -16384.
- R5: Each accepted sample gives at most one pulse, never both. `integ_o` moves by +1 for an up pulse and by -1 for a down pulse, reported in the same cycle.
- R6: `up_en` = 0 blocks up pulses and `dn_en` = 0 blocks down pulses. The two enables are independent.
- R7: With both enables at 0, `integ_o` holds its value exactly, whatever the sample.
- R8: The counter stops at the signed maximum 2^(CNT_W-1)-1 and at the signed minimum -2^(CNT_W-1). It never wraps.
- R9: `in_ready` is 1 from the first cycle after reset. `out_valid` is 1 exactly one cycle after an accepted sample. Without an accepted sample, `integ_o` does not change.
- R10: Reset reloads the LFSR with a fixed nonzero seed. After any reset, the same sample sequence gives the same pulse sequence. The LFSR state is never zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample present |
| in_ready | output | 1 | Block accepts samples (high after reset) |
| in_sample | input | DATA_W | Signed sample x |
| range_c | input | DATA_W | Unsigned full-scale constant C, at most 2^(DATA_W-1) |
| up_en | input | 1 | Enable for the counter's up port |
| dn_en | input | 1 | Enable for the counter's down port |
| out_valid | output | 1 | One-cycle strobe after each accepted sample |
| integ_o | output | CNT_W | Signed integral state |
| pulse_up_o | output | 1 | Up pulse applied by the last accepted sample |
| pulse_dn_o | output | 1 | Down pulse applied by the last accepted sample |

## Verification
The assertions check on every cycle the properties that follow from a single cycle:
- the full-scale corners force the bit;
- a disabled port never pulses;
- up and down pulses never occur together;
- the count never wraps, steps by at most one, and holds when neither port pulses;
- `out_valid` appears only after an accepted sample;
- the LFSR never reaches the all-zero state.

Only the bench scenarios can show the statistical behaviour of the bitstream over thousands of samples. The same holds for saturation reached after long runs in one direction and for the repeated pulse sequence after reset. A scoreboard model also follows the count through every result.

// File: rtl/sib_pkg.sv
package sib_pkg;
  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DOWN = 2'd2
  } step_e;
endpackage

// File: rtl/sib_lfsr.sv
// Galois LFSR; advances one step per accepted sample.
module sib_lfsr #(
  parameter int          W    = 16,
  parameter logic [W-1:0] POLY = 16'hB400,
  parameter logic [W-1:0] SEED = 16'hACE1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         adv_i,
  output logic [W-1:0] state_o
);
  logic [W-1:0] state_q;
  logic [W-1:0] nxt;

  for (genvar i = 0; i < W; i++) begin : g_tap
    if (i == W - 1) begin : g_top
      assign nxt[i] = POLY[i] & state_q[0];
    end else begin : g_mid
      assign nxt[i] = state_q[i+1] ^ (POLY[i] & state_q[0]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        state_q <= SEED;
    else if (adv_i) state_q <= nxt;
  end

  assign state_o = state_q;

  AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (rst)
    state_q != '0); // R10
endmodule

// File: rtl/sib_randomizer.sv
// Maps a uniform LFSR word r onto [-C, C) and emits (scaled r < x).
// Rewritten without division: bit = floor(r*2C / 2^W) < x + C
//                                 <=> r*2C < (x + C) * 2^W, for x + C > 0.
module sib_randomizer #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0]        rand_i,
  input  logic signed [DATA_W-1:0] x_i,
  input  logic [DATA_W-1:0]        c_i,
  output logic                     bit_o
);
  localparam int PW = 2 * DATA_W + 2;
  localparam int XW = DATA_W + 2;

  logic [PW-1:0]        prod;
  logic [PW-1:0]        thresh;
  logic signed [XW-1:0] xc;
  logic                 xc_pos;

  always_comb begin
    xc     = $signed({{2{x_i[DATA_W-1]}}, x_i}) + $signed({2'b00, c_i});
    xc_pos = !xc[XW-1] && (xc != '0);
    prod   = PW'(rand_i) * PW'({c_i, 1'b0});
    thresh = {1'b0, xc[DATA_W:0], {DATA_W{1'b0}}};
    bit_o  = xc_pos && (prod < thresh);
  end
endmodule

// File: rtl/sib_updown_counter.sv
// Saturating signed up/down counter with separate pulse ports.
module sib_updown_counter #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             up_i,
  input  logic             dn_i,
  output logic [CNT_W-1:0] count_o
);
  import sib_pkg::*;

  localparam logic [CNT_W-1:0] MAXV = {1'b0, {(CNT_W-1){1'b1}}};
  localparam logic [CNT_W-1:0] MINV = {1'b1, {(CNT_W-1){1'b0}}};
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  step_e            step;
  logic [CNT_W-1:0] count_q;

  always_comb begin
    step = STEP_HOLD;
    if (up_i && !dn_i && count_q != MAXV)      step = STEP_UP;
    else if (dn_i && !up_i && count_q != MINV) step = STEP_DOWN;
  end

  always_ff @(posedge clk) begin
    if (rst) count_q <= '0;
    else begin
      case (step)
        STEP_UP:   count_q <= count_q + ONE;
        STEP_DOWN: count_q <= count_q - ONE;
        default:   count_q <= count_q;
      endcase
    end
  end

  assign count_o = count_q;

  AST_NO_WRAP_HI: assert property (@(posedge clk) disable iff (rst)
    ($past(count_o) == MAXV) |-> (count_o != MINV)); // R8
  AST_NO_WRAP_LO: assert property (@(posedge clk) disable iff (rst)
    ($past(count_o) == MINV) |-> (count_o != MAXV)); // R8
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!up_i && !dn_i) |=> $stable(count_o)); // R7
  AST_UNIT_STEP: assert property (@(posedge clk) disable iff (rst)
    ((count_o - $past(count_o)) == '0) || ((count_o - $past(count_o)) == ONE)
    || ((count_o - $past(count_o)) == '1)); // R5
endmodule

// File: rtl/stoch_integrator.sv
module stoch_integrator #(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 24
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic signed [DATA_W-1:0] in_sample,
  input  logic [DATA_W-1:0]        range_c,
  input  logic                     up_en,
  input  logic                     dn_en,
  output logic                     out_valid,
  output logic [CNT_W-1:0]         integ_o,
  output logic                     pulse_up_o,
  output logic                     pulse_dn_o
);
  logic              ready_q;
  logic              accept;
  logic [DATA_W-1:0] rnd;
  logic              sbit;
  logic              up_req;
  logic              dn_req;
  logic              ov_q, pu_q, pd_q;

  assign accept = in_valid && ready_q;

  sib_lfsr #(.W(16), .POLY(16'hB400), .SEED(16'hACE1)) u_lfsr (
    .clk(clk), .rst(rst), .adv_i(accept), .state_o(rnd)
  );

  sib_randomizer #(.DATA_W(DATA_W)) u_rand (
    .rand_i(rnd), .x_i(in_sample), .c_i(range_c), .bit_o(sbit)
  );

  assign up_req = accept && sbit && up_en;
  assign dn_req = accept && !sbit && dn_en;

  sib_updown_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .up_i(up_req), .dn_i(dn_req), .count_o(integ_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ready_q <= 1'b0;
      ov_q    <= 1'b0;
      pu_q    <= 1'b0;
      pd_q    <= 1'b0;
    end else begin
      ready_q <= 1'b1;
      ov_q    <= accept;
      pu_q    <= up_req;
      pd_q    <= dn_req;
    end
  end

  assign in_ready   = ready_q;
  assign out_valid  = ov_q;
  assign pulse_up_o = pu_q;
  assign pulse_dn_o = pd_q;

  AST_FULL_SCALE_UP: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && up_en && range_c != '0
     && $signed(in_sample) >= $signed({1'b0, range_c})) |=> pulse_up_o); // R2
  AST_FULL_SCALE_DN: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && dn_en && range_c != '0
     && $signed(in_sample) <= -$signed({1'b0, range_c})) |=> pulse_dn_o); // R3
  AST_ONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({pulse_up_o, pulse_dn_o})); // R5
  AST_UP_GATED: assert property (@(posedge clk) disable iff (rst)
    pulse_up_o |-> $past(up_en)); // R6
  AST_DN_GATED: assert property (@(posedge clk) disable iff (rst)
    pulse_dn_o |-> $past(dn_en)); // R6
  AST_OUT_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid && in_ready)); // R9
endmodule

// File: tb/test_stoch_integrator.sv
module test_stoch_integrator;
  localparam int DW   = 16;
  localparam int CW   = 8;
  localparam int CMAX = 127;
  localparam int CMIN = -128;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst = 1'b1, in_valid = 1'b0, in_ready;
  logic signed [DW-1:0] in_sample = '0;
  logic [DW-1:0] range_c = '0;
  logic up_en = 1'b0, dn_en = 1'b0;
  logic out_valid, pulse_up_o, pulse_dn_o;
  logic [CW-1:0] integ_o;

  stoch_integrator #(.DATA_W(DW), .CNT_W(CW)) i_stoch_integrator (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_sample(in_sample), .range_c(range_c), .up_en(up_en), .dn_en(dn_en),
    .out_valid(out_valid), .integ_o(integ_o),
    .pulse_up_o(pulse_up_o), .pulse_dn_o(pulse_dn_o)
  );

  typedef struct { int x; int c; bit ue; bit de; } item_t;
  item_t q[$];
  int checks = 0, fails = 0;
  int model = 0, n_up = 0;
  bit rec_en = 0;
  bit rec[$];

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (q.size() == 0) chk(0, "R9", "result without sample", 1, 0);
      else begin
        item_t it;
        int prev;
        it = q.pop_front();
        prev = model;
        if (it.x >= it.c) begin
          chk(pulse_up_o == it.ue, it.x > it.c ? "R2/over" : "R2", "up pulse at +C", pulse_up_o, it.ue);
          chk(!pulse_dn_o, "R2", "no down pulse at +C", pulse_dn_o, 0);
        end
        if (it.x <= -it.c) begin
          chk(pulse_dn_o == it.de, "R3", "down pulse at -C", pulse_dn_o, it.de);
          chk(!pulse_up_o, "R3", "no up pulse at -C", pulse_up_o, 0);
        end
        chk(!(pulse_up_o && !it.ue), "R6", "up pulse while disabled", pulse_up_o, 0);
        chk(!(pulse_dn_o && !it.de), "R6", "down pulse while disabled", pulse_dn_o, 0);
        chk(!(pulse_up_o && pulse_dn_o), "R5", "both pulses", 1, 0);
        if (pulse_up_o && !pulse_dn_o && model < CMAX) model++;
        if (pulse_dn_o && !pulse_up_o && model > CMIN) model--;
        chk(int'($signed(integ_o)) == model, "R5/R8", "count", int'($signed(integ_o)), model);
        if (!it.ue && !it.de)
          chk(int'($signed(integ_o)) == prev, "R7", "hold with both off", int'($signed(integ_o)), prev);
        n_up += int'(pulse_up_o);
        if (rec_en) rec.push_back(pulse_up_o);
      end
    end else if (!rst) begin
      chk(int'($signed(integ_o)) == model, "R9", "idle count stable", int'($signed(integ_o)), model);
    end
  end

  task automatic send(int x, int c, bit ue, bit de);
    item_t it;
    it.x = x; it.c = c; it.ue = ue; it.de = de;
    in_valid  = 1'b1;
    in_sample = DW'(x);
    range_c   = DW'(c);
    up_en     = ue;
    dn_en     = de;
    q.push_back(it);
    @(negedge clk);
  endtask

  task automatic idle(int n);
    in_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    in_valid = 1'b0;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk(integ_o == '0, "R1", "count in reset", int'(integ_o), 0);
    chk(!out_valid && !pulse_up_o && !pulse_dn_o, "R1", "outputs in reset", out_valid, 0);
    chk(!in_ready, "R1", "ready in reset", in_ready, 0);
    q.delete();
    model = 0;
    rst = 1'b0;
    @(negedge clk);
    chk(in_ready, "R9", "ready after reset", in_ready, 1);
  endtask

  bit first[$];
  initial begin
    do_reset();
    // R2 full scale up
    for (int i = 0; i < 10; i++) send(1000, 1000, 1, 1);
    idle(2);
    chk(int'($signed(integ_o)) == 10, "R2", "after 10 up", int'($signed(integ_o)), 10);
    // R3 full scale down
    for (int i = 0; i < 15; i++) send(-1000, 1000, 1, 1);
    idle(2);
    chk(int'($signed(integ_o)) == -5, "R3", "after 15 down", int'($signed(integ_o)), -5);
    // R6 independent gates
    for (int i = 0; i < 5; i++) send(1000, 1000, 0, 1);
    for (int i = 0; i < 5; i++) send(-1000, 1000, 1, 0);
    idle(2);
    chk(int'($signed(integ_o)) == -5, "R6", "gated directions", int'($signed(integ_o)), -5);
    // R7 both off, mixed samples
    for (int i = 0; i < 20; i++) send((i * 3001) % 32768 - 16000, 32768, 0, 0);
    idle(2);
    chk(int'($signed(integ_o)) == -5, "R7", "hold both off", int'($signed(integ_o)), -5);
    // R8 saturation, with out-of-range sample
    for (int i = 0; i < 140; i++) send(2000, 1000, 1, 1);
    idle(2);
    chk(int'($signed(integ_o)) == CMAX, "R8", "top saturation", int'($signed(integ_o)), CMAX);
    for (int i = 0; i < 270; i++) send(-1000, 1000, 1, 1);
    idle(2);
    chk(int'($signed(integ_o)) == CMIN, "R8", "bottom saturation", int'($signed(integ_o)), CMIN);
    // R4 statistics
    n_up = 0;
    for (int i = 0; i < 2000; i++) send(0, 32768, 1, 1);
    idle(2);
    chk(n_up >= 850 && n_up <= 1150, "R4", "ones for x=0", n_up, 1000);
    n_up = 0;
    for (int i = 0; i < 2000; i++) send(16384, 32768, 1, 1);
    idle(2);
    chk(n_up >= 1350 && n_up <= 1650, "R4", "ones for x=C/2", n_up, 1500);
    n_up = 0;
    for (int i = 0; i < 2000; i++) send(-16384, 32768, 1, 1);
    idle(2);
    chk(n_up >= 350 && n_up <= 650, "R4", "ones for x=-C/2", n_up, 500);
    // R10 reseed repeatability
    do_reset();
    rec.delete(); rec_en = 1;
    for (int i = 0; i < 40; i++) send(0, 32768, 1, 1);
    idle(2);
    rec_en = 0;
    first = rec;
    do_reset();
    rec.delete(); rec_en = 1;
    for (int i = 0; i < 40; i++) send(0, 32768, 1, 1);
    idle(2);
    rec_en = 0;
    begin
      int diff;
      diff = 0;
      for (int i = 0; i < 40; i++) if (first[i] != rec[i]) diff++;
      chk(rec.size() == 40 && diff == 0, "R10", "pulse sequence after reseed", diff, 0);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule